// File: doc/BRIEF.md
# Configurable Register/Latch Output Cell

This block is one output cell of a programmable-logic fabric. A group of product-term lines is masked by an allocation vector. The terms that are still enabled are ORed into one sum. A static polarity bit can then invert that sum. Static mode bits decide where the result goes next. It can pass straight to the cell output with no clock. It can be captured by an edge-triggered flip-flop on one of two global clocks. Or it can be held in a level-sensitive latch, which is transparent while the chosen global clock is high.

The storage element has two asynchronous controls: a clear and a set. When both are asserted, the clear wins. A global active-low power-up reset also empties the storage. The cell drives a pad output together with a separate pad output-enable. The fabric receives a dedicated feedback line. A select bit routes either the cell value or the incoming pad value onto that line. With the output enable low and the feedback taking the cell value, the register is buried: the pad serves as an input, and the stored state stays available to the fabric.

Top module: `mc_cell`

## Requirements
- R1: The sum is the OR of `pterm[i] & pt_alloc[i]` over all terms; when no term is allocated the sum is 0.
- R2: When `cfg_invert` is 1 the sum is inverted before it reaches the storage element or the bypass path.
- R3: With `cfg_mode` equal to 0 or 3 (bypass), `pad_o` follows the polarity-adjusted sum without any clock edge.
- R4: With `cfg_mode` equal to 1 (flip-flop), `pad_o` takes the polarity-adjusted sum on each rising edge of the selected clock and holds it between edges.
- R5: `cfg_clk_sel` 0 selects `gclk0` and 1 selects `gclk1`; edges of the unselected clock leave the stored value unchanged.
- R6: With `cfg_mode` equal to 2 (latch), `pad_o` follows the polarity-adjusted sum while the selected clock is high and holds the last value while it is low.
- R7: `areset` high forces the stored value to 0 at once, with no clock edge; it overrides clock edges, latch transparency and `apreset`.
- R8: `apreset` high while `areset` is low forces the stored value to 1 at once and overrides clock edges.
- R9: `rst_n` low clears the stored value to 0 without a clock edge.
- R10: `pad_oe` equals `oe`, and `pad_o` carries the cell value whatever the state of `oe`.
- R11: `fb` carries `pad_i` when `cfg_fb_pin` is 1 and the cell value when it is 0.
- R12: With `oe` low and `cfg_fb_pin` 0, `fb` keeps showing the stored value whatever `pad_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk0 | input | 1 | Global clock 0 |
| gclk1 | input | 1 | Global clock 1 |
| rst_n | input | 1 | Global power-up reset, active low |
| pterm | input | NUM_PT | Product-term lines from the array |
| pt_alloc | input | NUM_PT | Per-term allocation mask |
| cfg_invert | input | 1 | Polarity select, 1 inverts the sum |
| cfg_mode | input | 2 | 0/3 bypass, 1 flip-flop, 2 latch |
| cfg_clk_sel | input | 1 | 0 selects gclk0, 1 selects gclk1 |
| cfg_fb_pin | input | 1 | 1 routes the pad input onto the feedback |
| areset | input | 1 | Asynchronous clear, active high |
| apreset | input | 1 | Asynchronous set, active high |
| oe | input | 1 | Pad driver enable |
| pad_i | input | 1 | Value present at the pad |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable toward the pad |
| fb | output | 1 | Feedback line into the routing fabric |

## Verification
Several mask patterns are applied to the sum path: no term allocated, one allocated term, and a raised term sitting behind a masked-off bit. Together they separate masking from plain ORing, and setting the polarity bit on each pattern shows that the inversion is really applied. In flip-flop and latch modes, pulses on the selected clock, on the other clock and on neither show apart edge capture, clock selection and holding. Some pulses are given while the data changes during the high phase, which exposes a flip-flop where a latch should be and a latch where a flip-flop should be. Clear and set are raised alone and together across clock pulses, which shows their priority and that they override the clock. The feedback is tried with the pad input both opposite to and equal to the stored value.

// File: rtl/mc_pkg.sv
// Shared types of the output cell.
// Assumes: mode encodings are static between reconfigurations.
package mc_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_FLOP    = 2'd1,
        ST_LATCH   = 2'd2,
        ST_BYPASS2 = 2'd3
    } st_mode_e;
endpackage

// File: rtl/mc_sum.sv
// Product-term sum with programmable polarity.
// Assumes: allocation mask and polarity are static configuration.
module mc_sum #(
    parameter int NUM_PT = 16
) (
    input  logic [NUM_PT-1:0] pterm,
    input  logic [NUM_PT-1:0] pt_alloc,
    input  logic              invert,
    output logic              sum_pol
);
    localparam int LAST = NUM_PT - 1;

    logic [NUM_PT-1:0] masked;

    // Gate each product term with its allocation bit.
    for (genvar g = 0; g <= LAST; g++) begin : g_mask
        assign masked[g] = pterm[g] & pt_alloc[g];
    end

    // OR the allocated terms and apply polarity.
    always_comb begin
        sum_pol = (|masked) ^ invert;
    end
endmodule

// File: rtl/mc_store.sv
// Storage element of the cell: bypass, edge flip-flop or level latch.
// Assumes: clock select changes only while both clocks are low;
// the power-up reset acts through the same path as the async clear.
module mc_store
    import mc_pkg::*;
(
    input  logic     gclk0,
    input  logic     gclk1,
    input  logic     clk_sel,
    input  logic     rst_n,
    input  logic     areset,
    input  logic     apreset,
    input  st_mode_e mode,
    input  logic     d,
    output logic     cell_q
);
    logic clk_pick;
    logic clr_any;
    logic q_ff;
    logic q_lat;

    // Route the chosen global clock to the storage element.
    always_comb begin
        clk_pick = clk_sel ? gclk1 : gclk0;
    end

    // Merge the power-up reset into the asynchronous clear.
    always_comb begin
        clr_any = areset | ~rst_n;
    end

    // Edge-triggered storage with clear over set over clock.
    always_ff @(posedge clk_pick or posedge clr_any or posedge apreset) begin
        if (clr_any) begin
            q_ff <= 1'b0;
        end else if (apreset) begin
            q_ff <= 1'b1;
        end else begin
            q_ff <= d;
        end
    end

    // Level-sensitive storage, transparent while the chosen clock is high.
    always_latch begin
        if (clr_any) begin
            q_lat = 1'b0;
        end else if (apreset) begin
            q_lat = 1'b1;
        end else if (clk_pick) begin
            q_lat = d;
        end
    end

    // Pick the cell value according to the storage mode.
    always_comb begin
        case (mode)
            ST_FLOP:  cell_q = q_ff;
            ST_LATCH: cell_q = q_lat;
            default:  cell_q = d;
        endcase
    end

    // R4: with no async control on this edge or the last, the flop holds the data of the last edge
    p_flop_capture_r4: assert property (@(posedge clk_pick) disable iff (!rst_n)
        ($past(rst_n) && !areset && !apreset && !$past(areset) && !$past(apreset))
        |-> (q_ff == $past(d)));

    // R6: at the close of the transparent phase the latch matches its input
    p_latch_follow_r6: assert property (@(negedge clk_pick) disable iff (!rst_n)
        (!areset && !apreset) |-> (q_lat == d));

    // R7: the clear holds both storage elements at 0, even against the set
    p_clear_wins_r7: assert property (@(posedge clk_pick) disable iff (!rst_n)
        areset |-> (!q_ff && !q_lat));

    // R8: a set held alone keeps both storage elements at 1
    p_preset_holds_r8: assert property (@(posedge clk_pick) disable iff (!rst_n)
        ($past(rst_n) && apreset && !areset && $past(apreset) && !$past(areset))
        |-> (q_ff && q_lat));
endmodule

// File: rtl/mc_io.sv
// Pad driver interface and feedback selection of the cell.
// Assumes: the pad value is supplied by the surrounding pad ring.
module mc_io (
    input  logic cell_q,
    input  logic oe,
    input  logic pad_i,
    input  logic fb_pin,
    output logic pad_o,
    output logic pad_oe,
    output logic fb
);
    // Drive the pad and its enable from the cell.
    always_comb begin
        pad_o  = cell_q;
        pad_oe = oe;
    end

    // Choose what the routing fabric sees.
    always_comb begin
        fb = fb_pin ? pad_i : cell_q;
    end
endmodule

// File: rtl/mc_cell.sv
// Top of the configurable output cell: sum, storage and pad/feedback.
// Assumes: all cfg_* inputs are static during operation.
module mc_cell
    import mc_pkg::*;
#(
    parameter int NUM_PT = 16
) (
    input  logic              gclk0,
    input  logic              gclk1,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] pterm,
    input  logic [NUM_PT-1:0] pt_alloc,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_clk_sel,
    input  logic              cfg_fb_pin,
    input  logic              areset,
    input  logic              apreset,
    input  logic              oe,
    input  logic              pad_i,
    output logic              pad_o,
    output logic              pad_oe,
    output logic              fb
);
    logic     sum_pol;
    logic     cell_q;
    st_mode_e mode;

    // Decode the raw mode bits into the shared enum.
    always_comb begin
        mode = st_mode_e'(cfg_mode);
    end

    mc_sum #(.NUM_PT(NUM_PT)) u_sum (
        .pterm    (pterm),
        .pt_alloc (pt_alloc),
        .invert   (cfg_invert),
        .sum_pol  (sum_pol)
    );

    mc_store u_store (
        .gclk0   (gclk0),
        .gclk1   (gclk1),
        .clk_sel (cfg_clk_sel),
        .rst_n   (rst_n),
        .areset  (areset),
        .apreset (apreset),
        .mode    (mode),
        .d       (sum_pol),
        .cell_q  (cell_q)
    );

    mc_io u_io (
        .cell_q (cell_q),
        .oe     (oe),
        .pad_i  (pad_i),
        .fb_pin (cfg_fb_pin),
        .pad_o  (pad_o),
        .pad_oe (pad_oe),
        .fb     (fb)
    );
endmodule

// File: tb/tb_mc_cell.sv
module tb_mc_cell;
    localparam int CLK_PERIOD = 20;
    localparam int Q = CLK_PERIOD / 4;
    localparam int H = CLK_PERIOD / 2;
    localparam int NPT = 16;

    logic gclk0, gclk1, rst_n;
    logic [NPT-1:0] pterm, pt_alloc;
    logic cfg_invert, cfg_clk_sel, cfg_fb_pin;
    logic [1:0] cfg_mode;
    logic areset, apreset, oe, pad_i;
    logic pad_o, pad_oe, fb;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    mc_cell #(.NUM_PT(NPT)) dut (
        .gclk0(gclk0), .gclk1(gclk1), .rst_n(rst_n),
        .pterm(pterm), .pt_alloc(pt_alloc), .cfg_invert(cfg_invert),
        .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_fb_pin(cfg_fb_pin),
        .areset(areset), .apreset(apreset), .oe(oe), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
    );

    // pulse: 0 none, 1 gclk0, 2 gclk1
    typedef struct packed {
        logic [1:0]  mode;
        logic        inv;
        logic        csel;
        logic [15:0] alloc;
        logic [15:0] pt;
        logic [1:0]  pulse;
        logic        exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 2'd0, 1'b0}, // R1 nothing allocated
        '{2'd0, 1'b0, 1'b0, 16'h0001, 16'h0001, 2'd0, 1'b1}, // R1 R3 one term
        '{2'd0, 1'b1, 1'b0, 16'h0001, 16'h0001, 2'd0, 1'b0}, // R2 inverted
        '{2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd0, 1'b1}, // R2 empty sum inverted
        '{2'd0, 1'b0, 1'b0, 16'h8000, 16'h7FFF, 2'd0, 1'b0}, // R1 masked terms
        '{2'd3, 1'b0, 1'b0, 16'h0010, 16'h0010, 2'd0, 1'b1}, // R3 mode 3 bypass
        '{2'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0100, 2'd1, 1'b1}, // R4 capture on gclk0
        '{2'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'd2, 1'b1}, // R5 other clock ignored
        '{2'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'd0, 1'b1}, // R4 hold without edge
        '{2'd1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'd1, 1'b0}, // R4 capture 0
        '{2'd1, 1'b0, 1'b1, 16'hFFFF, 16'h0002, 2'd1, 1'b0}, // R5 gclk0 ignored when sel 1
        '{2'd1, 1'b0, 1'b1, 16'hFFFF, 16'h0002, 2'd2, 1'b1}, // R5 gclk1 captures
        '{2'd1, 1'b1, 1'b1, 16'hFFFF, 16'h0002, 2'd2, 1'b0}, // R2 R4 inverted capture
        '{2'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 2'd1, 1'b1}, // R6 latch loads
        '{2'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'd0, 1'b1}, // R6 latch holds while low
        '{2'd2, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 2'd2, 1'b0}  // R5 R6 latch on gclk1
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(input logic [1:0] which);
        if (which == 2'd1) gclk0 = 1'b1;
        if (which == 2'd2) gclk1 = 1'b1;
        #H;
        gclk0 = 1'b0;
        gclk1 = 1'b0;
        #Q;
    endtask

    task automatic pulse_sel();
        pulse(cfg_clk_sel ? 2'd2 : 2'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 4000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        gclk0 = 0; gclk1 = 0; rst_n = 0;
        pterm = '1; pt_alloc = '1; cfg_invert = 0; cfg_mode = 2'd1;
        cfg_clk_sel = 0; cfg_fb_pin = 0; areset = 0; apreset = 0;
        oe = 1; pad_i = 0;
        #Q;
        pulse(2'd1);
        chk("R9 reset clears flop", pad_o, 1'b0);
        cfg_mode = 2'd2;
        #Q;
        chk("R9 reset clears latch", pad_o, 1'b0);
        rst_n = 1;
        #Q;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            cfg_mode = VEC[i].mode; cfg_invert = VEC[i].inv;
            cfg_clk_sel = VEC[i].csel; pt_alloc = VEC[i].alloc; pterm = VEC[i].pt;
            #Q;
            pulse(VEC[i].pulse);
            chk($sformatf("R1-vector %0d (R3 R4 R5 R6)", i), pad_o, VEC[i].exp);
        end

        // R6 transparency during the high phase
        cfg_mode = 2'd2; cfg_clk_sel = 0; pt_alloc = '1; cfg_invert = 0; pterm = '0;
        #Q;
        gclk0 = 1;
        #Q; pterm = 16'h0004;
        #Q; chk("R6 follows while high", pad_o, 1'b1);
        pterm = '0;
        #Q; chk("R6 follows back to 0", pad_o, 1'b0);
        pterm = 16'h0004;
        #Q; gclk0 = 0;
        #Q; pterm = '0;
        #Q; chk("R6 holds after fall", pad_o, 1'b1);

        // R4 flop does not follow data while clock high
        cfg_mode = 2'd1; pterm = '0;
        #Q; pulse(2'd1);
        gclk0 = 1;
        #Q; pterm = 16'h0001;
        #Q; chk("R4 no change while high", pad_o, 1'b0);
        gclk0 = 0;
        #Q; pterm = '0;
        #Q;

        // R8 set alone, no clock
        apreset = 1;
        #Q; chk("R8 preset immediate", pad_o, 1'b1);
        pulse_sel();
        chk("R8 preset over clock", pad_o, 1'b1);
        apreset = 0;
        #Q; pulse_sel();
        chk("R4 capture after preset", pad_o, 1'b0);

        // R7 clear wins over set
        pterm = 16'h0001;
        #Q; pulse_sel();
        areset = 1; apreset = 1;
        #Q; chk("R7 clear beats preset", pad_o, 1'b0);
        pulse_sel();
        chk("R7 clear over clock", pad_o, 1'b0);
        areset = 0; apreset = 0;
        #Q; pulse_sel();
        pulse_sel();

        // R7 clear in latch mode
        cfg_mode = 2'd2;
        #Q; chk("R6 latch holds 1", pad_o, 1'b1);
        areset = 1;
        #Q; chk("R7 clear latch", pad_o, 1'b0);
        pulse_sel();
        chk("R7 clear over transparency", pad_o, 1'b0);
        areset = 0;
        #Q; pulse_sel();

        // R9 mid-run reset in flop mode
        cfg_mode = 2'd1;
        #Q; pulse_sel();
        chk("R4 flop holds 1", pad_o, 1'b1);
        rst_n = 0;
        #Q; chk("R9 reset without clock", pad_o, 1'b0);
        pulse_sel();
        rst_n = 1;
        #Q; pulse_sel();
        pulse_sel();

        // R10 R11 R12 pad and feedback
        chk("R10 pad_oe high", pad_oe, 1'b1);
        oe = 0; pad_i = 0; cfg_fb_pin = 0;
        #Q; chk("R10 pad_oe low", pad_oe, 1'b0);
        chk("R10 pad_o keeps value", pad_o, 1'b1);
        chk("R12 buried fb", fb, 1'b1);
        pad_i = 1;
        #Q; pad_i = 0;
        #Q; chk("R12 fb ignores pad", fb, 1'b1);
        cfg_fb_pin = 1;
        #Q; chk("R11 fb takes pad 0", fb, 1'b0);
        pad_i = 1;
        #Q; chk("R11 fb takes pad 1", fb, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule